// File: doc/BRIEF.md
# Multi-lane serial byte aligner

This block takes several serial lanes, each delivering one bit per clock, and turns them into bytes that share one byte boundary. Only lane 0 has a pattern detector. The detector looks at the last eight bits of lane 0 at every bit position. When those bits form the sync byte, the block locks and counts bit positions modulo eight from that point.

Once locked, every lane hands over a byte at the same moment, once every eight clocks. A single valid strobe marks each new set of bytes. The lock indication is a port, so logic downstream can see whether the bytes are framed yet. Lock holds until reset or until a start-of-transmission re-arm pulse clears it. After a re-arm the search starts again.

Top module: `laneByteAligner`

## Requirements
- R1: After reset, `byteSync` is 0, `byteValid` is 0 and `byteData` is all zeros.
- R2: Bits are taken with the first-received bit as the LSB of a window. `byteSync` rises at the clock edge that follows the edge sampling the last bit of a lane-0 window equal to 8'hB8, that is, the bit sequence 0,0,0,1,1,1,0,1 in arrival order.
- R3: The sync byte on lanes 1 to 3 has no effect: `byteSync` stays 0.
- R4: While locked, `byteValid` is high for exactly one cycle in every eight. The first pulse follows the edge that samples the eighth bit after the sync byte. It is never high while `byteSync` is 0.
- R5: On a `byteValid` cycle, lane k's byte sits at `byteData[8k+7:8k]`, with its first-received bit in the LSB. The first byte reported after lock is the byte that follows the sync byte.
- R6: All lanes are framed on the boundary that lane 0 sets, and all lanes present their bytes on the same strobe.
- R7: While locked, a further sync byte on lane 0, at any bit offset, neither moves the byte boundary nor drops the lock.
- R8: A cycle with `rearm` high clears `byteSync` and `byteValid` at that edge. The search then resumes, and the next sync byte on lane 0 sets a new boundary.
- R9: `byteData` keeps its value in every cycle in which `byteValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per lane per rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rearm | input | 1 | Start-of-transmission re-arm; drops lock and restarts the search |
| serialIn | input | NUM_LANES (4) | One serial bit per lane; bit k is lane k |
| byteData | output | NUM_LANES*BYTE_W (32) | Framed bytes, lane k in bits [8k+7:8k] |
| byteValid | output | 1 | One-cycle strobe marking a new set of bytes |
| byteSync | output | 1 | Byte lock status shared by all lanes |

## Verification
Suppose the design records the wrong bit phase at lock. Then every lane's byte is misframed at once, and the error shows at the first strobe, eight clocks after lock. A bit counter that drifts or wraps wrongly shows up as a strobe on the wrong cycle within one byte period. A lock that ignores re-arm, or that re-locks while already locked, shows on `byteSync` or `byteData` within a byte. The bench's reference model compares all three outputs on every clock, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/alignPkg.sv
`timescale 1ns/1ps
package alignPkg;

  typedef enum logic {
    ALIGN_SEARCH = 1'b0,
    ALIGN_LOCKED = 1'b1
  } alignStateT;

  typedef struct packed {
    logic searchEn;
    logic capture;
  } ctrlStrobeT;

endpackage

// File: rtl/alignDatapath.sv
`timescale 1ns/1ps
module alignDatapath
  import alignPkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SYNC_WORD = 8'hB8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LANES-1:0]          serialIn,
  input  ctrlStrobeT                    strobes,
  output logic                          matchHit,
  output logic [NUM_LANES*BYTE_W-1:0]   dataOut
);

  localparam int DATA_W = NUM_LANES * BYTE_W;

  logic [BYTE_W-1:0] laneSr   [NUM_LANES];
  logic [BYTE_W-1:0] laneNext [NUM_LANES];
  logic [BYTE_W-1:0] laneData [NUM_LANES];

  for (genvar l = 0; l < NUM_LANES; l++) begin : gLane
    // newest bit enters at the MSB, so the oldest bit ends up as LSB
    assign laneNext[l] = {serialIn[l], laneSr[l][BYTE_W-1:1]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneSr[l] <= '0;
      end else begin
        laneSr[l] <= laneNext[l];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneData[l] <= '0;
      end else if (strobes.capture) begin
        laneData[l] <= laneNext[l];
      end
    end

    assign dataOut[l*BYTE_W +: BYTE_W] = laneData[l];
  end

  // only lane 0 carries a detector
  assign matchHit = strobes.searchEn && (laneSr[0] == SYNC_WORD);

  if (DATA_W < 1) begin : gBadWidth
    initial $error("alignDatapath: empty data path");
  end

endmodule

// File: rtl/alignControl.sv
`timescale 1ns/1ps
module alignControl
  import alignPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rearm,
  input  logic       matchHit,
  output ctrlStrobeT strobes,
  output logic       byteSync,
  output logic       byteValid
);

  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(1 % BYTE_W);

  alignStateT       state;
  logic [CNT_W-1:0] bitCnt;
  logic             validQ;

  always_comb begin
    strobes.searchEn = (state == ALIGN_SEARCH) && !rearm;
    strobes.capture  = (state == ALIGN_LOCKED) && (bitCnt == LAST_BIT) && !rearm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ALIGN_SEARCH;
      bitCnt <= '0;
      validQ <= 1'b0;
    end else if (rearm) begin
      state  <= ALIGN_SEARCH;
      bitCnt <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobes.capture;
      if (matchHit) begin
        state  <= ALIGN_LOCKED;
        bitCnt <= FIRST_BIT;
      end else if (state == ALIGN_LOCKED) begin
        bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  assign byteSync  = (state == ALIGN_LOCKED);
  assign byteValid = validQ;

  // R2
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteSync) |-> $past(matchHit));

  // R4
  valid_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> byteSync);

  // R4
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteSync && !rearm) |=> byteSync);

  // R8
  rearm_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rearm |=> (!byteSync && !byteValid));

endmodule

// File: rtl/laneByteAligner.sv
`timescale 1ns/1ps
module laneByteAligner
  import alignPkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SYNC_WORD = 8'hB8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rearm,
  input  logic [NUM_LANES-1:0]        serialIn,
  output logic [NUM_LANES*BYTE_W-1:0] byteData,
  output logic                        byteValid,
  output logic                        byteSync
);

  ctrlStrobeT strobes;
  logic       matchHit;

  alignDatapath #(
    .NUM_LANES (NUM_LANES),
    .BYTE_W    (BYTE_W),
    .SYNC_WORD (SYNC_WORD)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .serialIn (serialIn),
    .strobes  (strobes),
    .matchHit (matchHit),
    .dataOut  (byteData)
  );

  alignControl #(
    .BYTE_W (BYTE_W)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .rearm     (rearm),
    .matchHit  (matchHit),
    .strobes   (strobes),
    .byteSync  (byteSync),
    .byteValid (byteValid)
  );

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> $stable(byteData));

endmodule

// File: tb/laneByteAligner_tb.sv
`timescale 1ns/1ps
module laneByteAligner_tb;

  localparam int NL = 4;
  localparam int BW = 8;
  localparam logic [7:0] SYNC = 8'hB8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rearm = 1'b0;
  logic [NL-1:0] serialIn = '0;
  logic [NL*BW-1:0] byteData;
  logic          byteValid;
  logic          byteSync;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  laneByteAligner u_dut (
    .clk(clk), .rstN(rstN), .rearm(rearm), .serialIn(serialIn),
    .byteData(byteData), .byteValid(byteValid), .byteSync(byteSync)
  );

  // behavioural reference state
  bit          hist [NL][$];
  bit          mSync;
  int          mCnt;
  bit          mValid;
  logic [NL*BW-1:0] mData;

  function automatic logic [7:0] windowOf(int l);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = hist[l][hist[l].size() - 8 + i];
    return v;
  endfunction

  task automatic modelReset();
    for (int l = 0; l < NL; l++) begin
      hist[l].delete();
      for (int i = 0; i < 8; i++) hist[l].push_back(1'b0);
    end
    mSync = 0; mCnt = 0; mValid = 0; mData = '0;
  endtask

  task automatic modelEdge(logic [NL-1:0] bits, logic rr);
    bit prevMatch;
    prevMatch = (windowOf(0) == SYNC);
    for (int l = 0; l < NL; l++) begin
      hist[l].push_back(bits[l]);
      void'(hist[l].pop_front());
    end
    if (rr) begin
      mSync = 0; mCnt = 0; mValid = 0;
    end else if (!mSync && prevMatch) begin
      mSync = 1; mCnt = 1; mValid = 0;
    end else if (mSync) begin
      if (mCnt == 7) begin
        mValid = 1; mCnt = 0;
        for (int l = 0; l < NL; l++) mData[l*8 +: 8] = windowOf(l);
      end else begin
        mValid = 0; mCnt++;
      end
    end else begin
      mValid = 0;
    end
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    check("R2/R8 byteSync", 64'(byteSync), 64'(mSync));
    check("R4 byteValid", 64'(byteValid), 64'(mValid));
    check(mValid ? "R5 byteData" : "R9 byteData hold", 64'(byteData), 64'(mData));
  endtask

  task automatic step(logic [NL-1:0] bits, logic rr);
    @(negedge clk);
    serialIn = bits;
    rearm = rr;
    @(posedge clk);
    modelEdge(bits, rr);
    #1;
    compareModel();
  endtask

  task automatic sendBytes(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
    for (int i = 0; i < 8; i++) step({b3[i], b2[i], b1[i], b0[i]}, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 byteSync", 64'(byteSync), 0);
    check("R1 byteValid", 64'(byteValid), 0);
    check("R1 byteData", 64'(byteData), 0);

    // R3 sync byte on a non-detecting lane
    sendBytes(8'h00, 8'h11, 8'hB8, 8'h5A);
    sendBytes(8'h00, 8'hB8, 8'hB8, 8'hB8);
    check("R3 byteSync", 64'(byteSync), 0);

    // lock on lane 0 at an odd bit offset
    for (int i = 0; i < 3; i++) step('0, 1'b0);
    sendBytes(8'hB8, 8'h21, 8'h43, 8'h65);
    sendBytes(8'h3C, 8'hA5, 8'h0F, 8'hF0);
    check("R2 byteSync", 64'(byteSync), 1);
    check("R4 first strobe", 64'(byteValid), 1);
    check("R5 first payload", 64'(byteData), 64'h F00FA53C);

    // R6 shared boundary across lanes
    sendBytes(8'h96, 8'h96, 8'h96, 8'h96);
    check("R6 lanes aligned", 64'(byteData), 64'h96969696);

    // R7 misaligned sync byte while locked
    sendBytes(8'h80, 8'h01, 8'h02, 8'h03);
    check("R7 byte A", 64'(byteData), 64'h03020180);
    sendBytes(8'h0B, 8'h04, 8'h05, 8'h06);
    check("R7 byte B", 64'(byteData), 64'h0605040B);
    check("R7 lock kept", 64'(byteSync), 1);

    // R9 hold between strobes
    held = byteData;
    step('0, 1'b0);
    check("R9 no strobe", 64'(byteValid), 0);
    check("R9 data held", 64'(byteData), 64'(held));

    // R8 re-arm and re-lock at a new phase
    step('0, 1'b1);
    check("R8 sync cleared", 64'(byteSync), 0);
    check("R8 valid cleared", 64'(byteValid), 0);
    for (int i = 0; i < 5; i++) step('0, 1'b0);
    check("R8 still searching", 64'(byteSync), 0);
    sendBytes(8'hB8, 8'h00, 8'h00, 8'h00);
    sendBytes(8'h5E, 8'h6F, 8'h70, 8'h81);
    check("R8 relock strobe", 64'(byteValid), 1);
    check("R8 relock data", 64'(byteData), 64'h81706F5E);

    // randomised traffic, compared cycle by cycle
    for (int n = 0; n < 4000; n++) begin
      step(NL'($urandom), ($urandom % 200) == 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule